// File: doc/BRIEF.md
# One-Hot Row Waveform Shift Register

This block drives the row-select lines of an image sensor's overflow-gate analog multiplexers. It is a long chain of stages, one stage per pixel row, each holding a one-hot selector that picks one of several analog supply levels for its row. Words enter at the head of the chain. On each cycle where the advance enable is high, every stage hands its word to the next row. Each row therefore steps through the sequence of levels that was entered. A row sees that sequence one advance later than the row before it, which gives the staggered timing that progressive-scan readout needs.

The sequence of words entered sets the whole level staircase, and with it the pixel compression curve. Input words are checked at the head. A word with no bit set, or with more than one bit set, is never stored. Level line 0 goes in its place, and an error flag pulses. The last stage is also driven out on its own port, so chains can be cascaded or the stream can be monitored.

Top module: `rowWaveShifter`

## Requirements
- R1: While `rst` is high at a rising clock edge, every row stage is loaded with the line-0 selector (bit 0 set, all other bits clear). This is visible on `rowSel` and `tailWord` after that edge.
- R2: When `shiftEn` is high and `wordIn` has exactly one bit set, row 0 holds `wordIn` after the edge. Bit k of a row's word selects analog line k.
- R3: `badWord` is high for the single cycle after an edge at which `shiftEn` was high and `wordIn` had zero or several bits set. In every other cycle it is low.
- R4: A rejected word is never stored. Row 0 receives the line-0 selector instead.
- R5: When `shiftEn` is low, no row changes and `badWord` stays low, whatever `wordIn` holds.
- R6: When `shiftEn` is high, row r (r >= 1) takes the word that row r-1 held before the edge.
- R7: `tailWord` always equals the word of the last row, NUM_ROWS-1.
- R8: Reset takes priority over shifting. An edge with both `rst` and `shiftEn` high clears the chain as in R1 and leaves `badWord` low.
- R9: `rowSel` places row r at bits [r*LEVELS +: LEVELS], with row 0 as the head.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| shiftEn | input | 1 | Advance enable for the chain |
| wordIn | input | LEVELS | Candidate selector word for the head row |
| rowSel | output | NUM_ROWS*LEVELS | Per-row one-hot selectors, row r at bits r*LEVELS |
| tailWord | output | LEVELS | Word held by the last row |
| badWord | output | 1 | One-cycle pulse after a rejected word |

## Verification
A corrupted stage appears directly on that row's slice of `rowSel` in the cycle after the faulty edge. After further advances it also travels down the chain, so a wrong head word reaches `tailWord` NUM_ROWS advances later. A broken validity check shows up in two places one cycle after the edge: a flag pulse that is missing or appears where none is due, and a head word that is not line 0. The sweep applies every possible 8-bit input with enable both on and off, and compares every row on every cycle. Any of these faults is therefore caught within one cycle of its cause.

// File: rtl/rws_pkg.sv
package rws_pkg;
  // Strobes from control to the stage chain
  typedef struct packed {
    logic clear;       // load every stage with the default selector
    logic shift;       // advance the chain by one row
    logic useDefault;  // head takes the default selector, not the input
  } ctrlStrobes_t;
endpackage

// File: rtl/rwsCtrl.sv
module rwsCtrl
  import rws_pkg::*;
#(
  parameter int LEVELS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shiftEn,
  input  logic [LEVELS-1:0] wordIn,
  output ctrlStrobes_t      str,
  output logic [LEVELS-1:0] headWord,
  output logic              badWord
);
  localparam int CNT_W = $clog2(LEVELS + 1);
  localparam logic [LEVELS-1:0] DEFAULT_SEL = {{(LEVELS-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] bitCount;
  logic             wordOk;

  always_comb begin
    bitCount = '0;
    for (int k = 0; k < LEVELS; k++) begin
      bitCount = bitCount + CNT_W'(wordIn[k]);
    end
  end

  assign wordOk         = (bitCount == CNT_W'(1));
  assign str.clear      = rst;
  assign str.shift      = shiftEn && !rst;
  assign str.useDefault = !wordOk;
  assign headWord       = wordOk ? wordIn : DEFAULT_SEL;

  always_ff @(posedge clk) begin
    if (rst) badWord <= 1'b0;
    else     badWord <= shiftEn && !wordOk;
  end

  // R3
  err_needs_shift_chk: assert property (@(posedge clk) disable iff (rst)
    badWord |-> $past(shiftEn));

  // R5
  err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(shiftEn) |-> !badWord);
endmodule

// File: rtl/rwsChain.sv
module rwsChain
  import rws_pkg::*;
#(
  parameter int NUM_ROWS = 256,
  parameter int LEVELS   = 8
) (
  input  logic                       clk,
  input  ctrlStrobes_t               str,
  input  logic [LEVELS-1:0]          headWord,
  output logic [NUM_ROWS*LEVELS-1:0] rowFlat,
  output logic [LEVELS-1:0]          tail
);
  localparam logic [LEVELS-1:0] DEFAULT_SEL = {{(LEVELS-1){1'b0}}, 1'b1};
  localparam int LAST = NUM_ROWS - 1;

  logic [LEVELS-1:0] stage [NUM_ROWS];

  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
    if (r == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (str.clear)      stage[r] <= DEFAULT_SEL;
        else if (str.shift) stage[r] <= headWord;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (str.clear)      stage[r] <= DEFAULT_SEL;
        else if (str.shift) stage[r] <= stage[r-1];
      end
    end
    assign rowFlat[r*LEVELS +: LEVELS] = stage[r];

    // R2
    row_onehot_chk: assert property (@(posedge clk) disable iff (str.clear)
      $onehot(stage[r]));
  end

  assign tail = stage[LAST];

  // R5
  hold_tail_chk: assert property (@(posedge clk) disable iff (str.clear)
    !$past(str.shift) && !$past(str.clear) |-> $stable(tail));

  // R1
  clear_tail_chk: assert property (@(posedge clk) disable iff (str.clear)
    $past(str.clear) |-> tail == DEFAULT_SEL);

  // R4
  default_head_chk: assert property (@(posedge clk) disable iff (str.clear)
    $past(str.shift && str.useDefault) |-> stage[0] == DEFAULT_SEL);
endmodule

// File: rtl/rowWaveShifter.sv
module rowWaveShifter
  import rws_pkg::*;
#(
  parameter int NUM_ROWS = 256,
  parameter int LEVELS   = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       shiftEn,
  input  logic [LEVELS-1:0]          wordIn,
  output logic [NUM_ROWS*LEVELS-1:0] rowSel,
  output logic [LEVELS-1:0]          tailWord,
  output logic                       badWord
);
  ctrlStrobes_t      str;
  logic [LEVELS-1:0] headWord;

  rwsCtrl #(.LEVELS(LEVELS)) uCtrl (
    .clk(clk), .rst(rst), .shiftEn(shiftEn), .wordIn(wordIn),
    .str(str), .headWord(headWord), .badWord(badWord)
  );

  rwsChain #(.NUM_ROWS(NUM_ROWS), .LEVELS(LEVELS)) uChain (
    .clk(clk), .str(str), .headWord(headWord),
    .rowFlat(rowSel), .tail(tailWord)
  );

  // R8
  rst_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> !badWord);
endmodule

// File: tb/tb_rowWaveShifter.sv
module tb_rowWaveShifter;
  localparam int NR = 5;
  localparam int LV = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic shiftEn = 1'b0;
  logic [LV-1:0] wordIn = '0;
  logic [NR*LV-1:0] rowSel;
  logic [LV-1:0] tailWord;
  logic badWord;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [LV-1:0] mdl [NR];
  logic mdlBad;

  always #5 clk = ~clk;

  rowWaveShifter #(.NUM_ROWS(NR), .LEVELS(LV)) dut (
    .clk(clk), .rst(rst), .shiftEn(shiftEn), .wordIn(wordIn),
    .rowSel(rowSel), .tailWord(tailWord), .badWord(badWord)
  );

  function automatic bit oneHot(input logic [LV-1:0] w);
    int n = 0;
    for (int k = 0; k < LV; k++) n += int'(w[k]);
    return n == 1;
  endfunction

  task automatic chk(input string req, input logic [LV-1:0] act, input logic [LV-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // Apply one clock with the given inputs, update the model, compare all outputs.
  task automatic step(input logic r, input logic en, input logic [LV-1:0] w);
    string headReq;
    @(negedge clk);
    rst = r; shiftEn = en; wordIn = w;
    @(posedge clk);
    #1;
    if (r) begin
      for (int i = 0; i < NR; i++) mdl[i] = 8'h01;
      mdlBad = 1'b0;
      headReq = en ? "R8 reset over shift" : "R1 reset row";
    end else if (en) begin
      for (int i = NR-1; i > 0; i--) mdl[i] = mdl[i-1];
      mdl[0] = oneHot(w) ? w : 8'h01;
      mdlBad = !oneHot(w);
      headReq = oneHot(w) ? "R2 head load" : "R4 default head";
    end else begin
      mdlBad = 1'b0;
      headReq = "R5 hold head";
    end
    chk(headReq, rowSel[0 +: LV], mdl[0]);
    for (int i = 1; i < NR; i++)
      chk(r ? "R1 reset row" : (en ? "R6 stagger row R9" : "R5 hold row"),
          rowSel[i*LV +: LV], mdl[i]);
    chk("R7 tail", tailWord, mdl[NR-1]);
    chk(r ? "R8 flag in reset" : "R3 flag", {7'b0, badWord}, {7'b0, mdlBad});
  endtask

  initial begin
    for (int i = 0; i < NR; i++) mdl[i] = 8'h01;
    mdlBad = 1'b0;
    // R1: reset state
    step(1'b1, 1'b0, 8'h00);
    step(1'b1, 1'b0, 8'h55);
    // R2/R6: staircase of valid levels, progressive stagger
    for (int k = 0; k < 2*LV; k++) step(1'b0, 1'b1, 8'(1 << (k % LV)));
    // R3/R4/R5: every input word, enable on and off
    for (int w = 0; w < 256; w++) begin
      step(1'b0, 1'b1, 8'(w));
      step(1'b0, 1'b0, 8'(255 - w));
    end
    // R3: back-to-back rejects keep the flag high
    step(1'b0, 1'b1, 8'h00);
    step(1'b0, 1'b1, 8'hFF);
    step(1'b0, 1'b1, 8'h80);
    // R8: reset during shift with a bad word
    step(1'b0, 1'b1, 8'h40);
    step(1'b1, 1'b1, 8'h03);
    step(1'b0, 1'b1, 8'h20);
    for (int k = 0; k < NR; k++) step(1'b0, 1'b1, 8'h08);
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule